// File: doc/BRIEF.md
# XGMII Loopback Switch with Frame-Aligned Mode Change

This block sits on the 64-bit XGMII path between a 10G MAC and its PCS. In normal mode it passes the MAC transmit stream out to the PCS and the PCS receive stream in to the MAC. In loopback mode the MAC transmit stream is returned straight to the MAC receive input, and the line-side transmit output carries only idle characters.

The loopback request arrives on a single enable input. A mode change never cuts a frame. The switch waits for a beat on which both the MAC transmit stream and the PCS receive stream are idle and neither has a frame open. Every output is registered, so data appears one clock after it enters.

Top module: `xgmii_loop_switch`

## Requirements
- R1: In normal mode, `pcs_txd_o`/`pcs_txc_o` equal the MAC transmit beat presented one clock earlier.
- R2: In normal mode, `mac_rxd_o`/`mac_rxc_o` equal the PCS receive beat presented one clock earlier.
- R3: In loopback mode, `mac_rxd_o`/`mac_rxc_o` equal the MAC transmit beat presented one clock earlier.
- R4: In loopback mode, every lane of the PCS transmit output is idle: data byte 0x07 with its control bit set.
- R5: In loopback mode, the data and control values on the PCS receive input have no effect on the MAC receive output.
- R6: The enable is captured in a register. The mode takes the registered value only on a beat where every lane of both the MAC transmit input and the PCS receive input is idle (0x07, control set) and no frame is open on either stream. That beat's outputs already follow the new mode.
- R7: A frame opens on a beat whose lane 0 holds 0xFB with its control bit set. It closes on the beat in which any lane holds 0xFD with its control bit set. A beat that holds both opens no frame. While a frame is open, the mode does not change.
- R8: When loopback is turned off during a looped frame, that frame is delivered in full to the MAC receive output before normal mode resumes.
- R9: During and after reset, both outputs are all-idle and the mode is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_en_i | input | 1 | Loopback request |
| mac_txd_i | input | 64 | MAC transmit data |
| mac_txc_i | input | 8 | MAC transmit control, one bit per lane |
| mac_rxd_o | output | 64 | MAC receive data |
| mac_rxc_o | output | 8 | MAC receive control |
| pcs_txd_o | output | 64 | Line-side transmit data |
| pcs_txc_o | output | 8 | Line-side transmit control |
| pcs_rxd_i | input | 64 | Line-side receive data |
| pcs_rxc_i | input | 8 | Line-side receive control |

## Verification
Two events can fall in the same cycle. A pending enable change can meet the terminate beat of a MAC frame, and that same beat can overlap an open or just-closing frame on the PCS receive stream. The bench sweeps frame length, terminate lane, the cycle of the enable toggle and the offset of a concurrent receive frame, so the toggle lands before, on and after each terminate. Every cycle it compares both outputs with a mode computed from the stated switch rule. A mismatch is tagged with whichever rule was holding the switch back at that moment.

// File: rtl/xgmii_loop_switch.sv
module xgmii_loop_switch #(
  parameter int LANES = 8,
  localparam int DW = LANES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loop_en_i,
  input  logic [DW-1:0]    mac_txd_i,
  input  logic [LANES-1:0] mac_txc_i,
  output logic [DW-1:0]    mac_rxd_o,
  output logic [LANES-1:0] mac_rxc_o,
  output logic [DW-1:0]    pcs_txd_o,
  output logic [LANES-1:0] pcs_txc_o,
  input  logic [DW-1:0]    pcs_rxd_i,
  input  logic [LANES-1:0] pcs_rxc_i
);
  localparam logic [7:0] IDLE_B = 8'h07;
  localparam logic [7:0] SOF_B  = 8'hFB;
  localparam logic [7:0] EOF_B  = 8'hFD;
  localparam logic [DW-1:0]    IDLE_D = {LANES{IDLE_B}};
  localparam logic [LANES-1:0] IDLE_C = '1;

  logic en_q, mode_q, tx_open_q, rx_open_q;
  logic [LANES-1:0] tx_idle_l, tx_eof_l, rx_idle_l, rx_eof_l;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign tx_idle_l[i] = mac_txc_i[i] && mac_txd_i[8*i +: 8] == IDLE_B;
    assign tx_eof_l[i]  = mac_txc_i[i] && mac_txd_i[8*i +: 8] == EOF_B;
    assign rx_idle_l[i] = pcs_rxc_i[i] && pcs_rxd_i[8*i +: 8] == IDLE_B;
    assign rx_eof_l[i]  = pcs_rxc_i[i] && pcs_rxd_i[8*i +: 8] == EOF_B;
  end

  wire tx_sof  = mac_txc_i[0] && mac_txd_i[7:0] == SOF_B;
  wire rx_sof  = pcs_rxc_i[0] && pcs_rxd_i[7:0] == SOF_B;
  wire tx_eof  = |tx_eof_l;
  wire rx_eof  = |rx_eof_l;
  wire tx_open = tx_sof ? !tx_eof : (tx_open_q && !tx_eof);
  wire rx_open = rx_sof ? !rx_eof : (rx_open_q && !rx_eof);

  wire quiet  = &tx_idle_l && &rx_idle_l && !tx_open_q && !rx_open_q;
  wire mode_n = (en_q != mode_q && quiet) ? en_q : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      mode_q    <= 1'b0;
      tx_open_q <= 1'b0;
      rx_open_q <= 1'b0;
      pcs_txd_o <= IDLE_D;
      pcs_txc_o <= IDLE_C;
      mac_rxd_o <= IDLE_D;
      mac_rxc_o <= IDLE_C;
    end else begin
      en_q      <= loop_en_i;
      mode_q    <= mode_n;
      tx_open_q <= tx_open;
      rx_open_q <= rx_open;
      pcs_txd_o <= mode_n ? IDLE_D : mac_txd_i;
      pcs_txc_o <= mode_n ? IDLE_C : mac_txc_i;
      mac_rxd_o <= mode_n ? mac_txd_i : pcs_rxd_i;
      mac_rxc_o <= mode_n ? mac_txc_i : pcs_rxc_i;
    end
  end
endmodule

module xgmii_loop_switch_chk #(
  parameter int LANES = 8,
  localparam int DW = LANES * 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_q,
  input logic [DW-1:0]    mac_txd_i,
  input logic [LANES-1:0] mac_txc_i,
  input logic [DW-1:0]    mac_rxd_o,
  input logic [LANES-1:0] mac_rxc_o,
  input logic [DW-1:0]    pcs_txd_o,
  input logic [LANES-1:0] pcs_txc_o,
  input logic [DW-1:0]    pcs_rxd_i,
  input logic [LANES-1:0] pcs_rxc_i
);
  logic armed;
  logic [LANES-1:0] ti, ri;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0; else armed <= 1'b1;

  always_comb
    for (int i = 0; i < LANES; i++) begin
      ti[i] = mac_txc_i[i] && mac_txd_i[8*i +: 8] == 8'h07;
      ri[i] = pcs_rxc_i[i] && pcs_rxd_i[8*i +: 8] == 8'h07;
    end

  p_tx_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !mode_q |-> {pcs_txc_o, pcs_txd_o} == $past({mac_txc_i, mac_txd_i}));
  p_rx_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !mode_q |-> {mac_rxc_o, mac_rxd_o} == $past({pcs_rxc_i, pcs_rxd_i}));
  p_loopback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && mode_q |-> {mac_rxc_o, mac_rxd_o} == $past({mac_txc_i, mac_txd_i}));
  p_line_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (&pcs_txc_o && pcs_txd_o == {LANES{8'h07}}));
  p_switch_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && mode_q != $past(mode_q) |-> $past(&ti && &ri));
endmodule

bind xgmii_loop_switch xgmii_loop_switch_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q),
  .mac_txd_i(mac_txd_i), .mac_txc_i(mac_txc_i),
  .mac_rxd_o(mac_rxd_o), .mac_rxc_o(mac_rxc_o),
  .pcs_txd_o(pcs_txd_o), .pcs_txc_o(pcs_txc_o),
  .pcs_rxd_i(pcs_rxd_i), .pcs_rxc_i(pcs_rxc_i)
);

// File: tb/test_xgmii_loop_switch.sv
module test_xgmii_loop_switch;
  localparam int L = 8;
  localparam int DW = L * 8;
  localparam logic [DW+L-1:0] IDLE = {{L{1'b1}}, {L{8'h07}}};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, loop_en;
  logic [DW-1:0] mtd, prd, mrd, ptd;
  logic [L-1:0]  mtc, prc, mrc, ptc;
  int checks = 0, fails = 0;
  bit m_en, m_mode, m_txb, m_rxb;

  xgmii_loop_switch #(.LANES(L)) i_xgmii_loop_switch (
    .clk(clk), .rst_n(rst_n), .loop_en_i(loop_en),
    .mac_txd_i(mtd), .mac_txc_i(mtc), .mac_rxd_o(mrd), .mac_rxc_o(mrc),
    .pcs_txd_o(ptd), .pcs_txc_o(ptc), .pcs_rxd_i(prd), .pcs_rxc_i(prc));

  // kind: 0 idle, 1 start, 2 data, 3 terminate at lane
  function automatic logic [DW+L-1:0] beat(int kind, int lane, int seed);
    logic [DW-1:0] d; logic [L-1:0] c;
    for (int i = 0; i < L; i++) begin
      d[8*i +: 8] = 8'(seed * 13 + i * 7 + 1);
      c[i] = 1'b0;
      if (kind == 0 || (kind == 3 && i > lane)) begin d[8*i +: 8] = 8'h07; c[i] = 1'b1; end
      if (kind == 1 && i == 0) begin d[7:0] = 8'hFB; c[0] = 1'b1; end
      if (kind == 3 && i == lane) begin d[8*i +: 8] = 8'hFD; c[i] = 1'b1; end
    end
    return {c, d};
  endfunction

  function automatic bit has_eof(logic [DW+L-1:0] b);
    for (int i = 0; i < L; i++)
      if (b[DW+i] && b[8*i +: 8] == 8'hFD) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit is_sof(logic [DW+L-1:0] b);
    return b[DW] && b[7:0] == 8'hFB;
  endfunction

  task automatic check(string tag, logic [DW+L-1:0] act, logic [DW+L-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [DW+L-1:0] tx, logic [DW+L-1:0] rx, bit en);
    bit sw, nm;
    logic [DW+L-1:0] ep, er;
    string tp, tr;
    @(negedge clk);
    {mtc, mtd} = tx; {prc, prd} = rx; loop_en = en;
    sw = (m_en != m_mode) && tx == IDLE && rx == IDLE && !m_txb && !m_rxb;
    nm = sw ? m_en : m_mode;
    ep = nm ? IDLE : tx;
    er = nm ? tx : rx;
    tp = nm ? "R4" : "R1";
    tr = nm ? (rx != IDLE ? "R5" : "R3") : "R2";
    if (m_en != nm) tr = (nm && m_txb) ? "R8" : ((m_txb || m_rxb) ? "R7" : "R6");
    m_txb = is_sof(tx) ? !has_eof(tx) : (m_txb && !has_eof(tx));
    m_rxb = is_sof(rx) ? !has_eof(rx) : (m_rxb && !has_eof(rx));
    m_mode = nm;
    m_en = en;
    @(posedge clk); #1;
    check(tp, {ptc, ptd}, ep);
    check(tr, {mrc, mrd}, er);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit cur;
    rst_n = 1'b0; loop_en = 1'b0;
    {mtc, mtd} = IDLE; {prc, prd} = IDLE;
    repeat (3) @(negedge clk);
    check("R9", {ptc, ptd}, IDLE);
    check("R9", {mrc, mrd}, IDLE);
    rst_n = 1'b1;
    // R9: mode is normal after reset, so a data beat passes straight through
    step(beat(2, 0, 5), beat(2, 0, 9), 1'b0);
    step(IDLE, IDLE, 1'b0);
    cur = 1'b0;
    for (int len = 2; len <= 4; len++)
      for (int lane = 0; lane < L; lane++)
        for (int off = 0; off <= len + 2; off++)
          for (int rs = 0; rs <= 4; rs++) begin
            for (int c = 0; c < 12; c++) begin
              logic [DW+L-1:0] tx, rx;
              int sd;
              sd = len * 100 + lane * 10 + off + rs + c;
              tx = IDLE; rx = IDLE;
              if (c == 2) tx = beat(1, 0, sd);
              else if (c == 1 + len) tx = beat(3, lane, sd);
              else if (c > 2 && c < 1 + len) tx = beat(2, 0, sd);
              if (c == rs) rx = beat(1, 0, sd + 3);
              else if (c == rs + 2) rx = beat(3, L - 1 - lane, sd + 3);
              else if (c == rs + 1) rx = beat(2, 0, sd + 3);
              step(tx, rx, (c >= 2 + off) ? !cur : cur);
            end
            cur = !cur;
          end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule